// File: doc/BRIEF.md
# Programmable Digital Input Noise Filter

This block removes short glitches from one asynchronous input pin before the pin reaches a timer's capture logic. The pin is passed through a synchronizer. It is then sampled on a one-cycle strobe from a prescaler. The prescaler divides the peripheral clock by 1, 2, 4, 16, 32 or 64. The filtered level moves to a new value only after 3 consecutive samples (or 2, when so configured) all show that new value.

The block is configured through an 8-bit control register. The register can be written as a whole byte or one bit at a time, and it is always readable. When the `capture_mode` input is low, the pin is being used for event counting or as an external trigger. In that case the raw pin drives the output directly and the filter is bypassed.

The vote logic is a three-state machine:
- `FLT_INIT`: entered at reset. It waits for the synchronizer to fill. It then loads the synchronized level without voting (transition INIT→STEADY).
- `FLT_STEADY`: the level is settled. A strobe whose sample disagrees with the level moves to PENDING (STEADY→PENDING).
- `FLT_PENDING`: a change is being voted on. An agreeing sample abandons the change (PENDING→STEADY, level kept). Reaching the required count of disagreeing samples adopts the new level (PENDING→STEADY, level flipped).

Top module: `pin_glitch_filter`

## Requirements
- R1: After reset the control register reads 0x00.
- R2: Bits 7, 5, 4 and 3 of the control register always read back as 0, whatever was written to them.
- R3: A byte write stores bit 6 (sample-count select) and bits 2:0 (divider code), and both read back at the same positions.
- R4: A single-bit write (`cfg_bit_idx`, `cfg_bit_val`) changes only the addressed bit. Addressing a reserved bit changes nothing.
- R5: A write that would leave the divider code at 6 or 7 keeps the previous code (both in readback and in behaviour). Sampling continues at the previous rate.
- R6: Divider code 0..5 gives one sample every 1, 2, 4, 16, 32 or 64 clocks. Any write touching bits 2:0 restarts the prescaler, so that samples fall on edges E0+k·ratio (k≥1), where E0 is the write edge.
- R7: With bit 6 = 0 the output changes on the 3rd consecutive sample at the new level. With bit 6 = 1 it changes on the 2nd. A pin change before edge P is seen by samples at edges ≥ P+2.
- R8: A pulse covering fewer than the required number of samples never reaches the output.
- R9: When `capture_mode` is 0, `pin_out` equals `pin_raw` in the same cycle.
- R10: After reset the output stays 0 through the 2nd clock edge. At the 3rd edge it takes the pin level directly, without voting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_mode | input | 1 | 1: pin used as capture trigger (filtered); 0: bypass |
| cfg_byte_we | input | 1 | Byte write strobe for the control register |
| cfg_wdata | input | 8 | Byte write data |
| cfg_bit_we | input | 1 | Single-bit write strobe (byte write wins if both) |
| cfg_bit_idx | input | 3 | Bit position for a single-bit write |
| cfg_bit_val | input | 1 | Value for a single-bit write |
| cfg_rdata | output | 8 | Control register readback |
| pin_raw | input | 1 | Asynchronous input pin |
| pin_out | output | 1 | Filtered (or bypassed) pin level |

## Verification
The assertions assume that the sample-count bit is not changed while a level change is being voted on. They also assume that the divider code only moves through register writes, so that the prescaler count never exceeds the current limit. The stimulus writes configuration only while the filter is settled. It holds the pin steady long enough before and after each edge or pulse to respect these assumptions. All pin and control changes are made on the falling clock edge, so each sample edge in the bench is known exactly.

// File: rtl/pgf_pkg.sv
package pgf_pkg;

    localparam int unsigned SEL_W   = 3;
    localparam int unsigned LOG_MAX = 6;
    localparam int unsigned PRE_W   = LOG_MAX;
    localparam logic [SEL_W-1:0] SEL_LAST_LEGAL = 3'd5;

    typedef enum logic [1:0] {
        FLT_INIT    = 2'd0,
        FLT_STEADY  = 2'd1,
        FLT_PENDING = 2'd2
    } flt_state_e;

    // divider code -> log2 of the division ratio
    function automatic logic [2:0] sel_to_log(input logic [SEL_W-1:0] sel);
        logic [2:0] lg;
        case (sel)
            3'd0:    lg = 3'd0;
            3'd1:    lg = 3'd1;
            3'd2:    lg = 3'd2;
            3'd3:    lg = 3'd4;
            3'd4:    lg = 3'd5;
            default: lg = 3'd6;
        endcase
        return lg;
    endfunction

    // terminal count of the prescaler (ratio - 1)
    function automatic logic [PRE_W-1:0] sel_to_limit(input logic [SEL_W-1:0] sel);
        logic [PRE_W:0] pw;
        pw = (PRE_W+1)'(1) << sel_to_log(sel);
        return PRE_W'(pw - 1'b1);
    endfunction

endpackage

// File: rtl/pgf_cfg_reg.sv
module pgf_cfg_reg
    import pgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_we,
    input  logic [7:0]       wdata,
    input  logic             bit_we,
    input  logic [2:0]       bit_idx,
    input  logic             bit_val,
    output logic [7:0]       rdata,
    output logic             two_mode,
    output logic [SEL_W-1:0] sel,
    output logic             sel_touch
);
    localparam int unsigned CNT_BIT = 6;

    logic             two_q, two_d;
    logic [SEL_W-1:0] sel_q, sel_d, sel_cand;

    always_comb begin
        two_d     = two_q;
        sel_cand  = sel_q;
        sel_touch = 1'b0;
        if (byte_we) begin
            two_d     = wdata[CNT_BIT];
            sel_cand  = wdata[SEL_W-1:0];
            sel_touch = 1'b1;
        end else if (bit_we) begin
            if (bit_idx == 3'(CNT_BIT)) begin
                two_d = bit_val;
            end else if (bit_idx < 3'(SEL_W)) begin
                sel_cand[bit_idx[1:0]] = bit_val;
                sel_touch              = 1'b1;
            end
        end
        sel_d = (sel_cand <= SEL_LAST_LEGAL) ? sel_cand : sel_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            two_q <= 1'b0;
            sel_q <= '0;
        end else begin
            two_q <= two_d;
            sel_q <= sel_d;
        end
    end

    always_comb begin
        rdata              = '0;
        rdata[CNT_BIT]     = two_q;
        rdata[SEL_W-1:0]   = sel_q;
    end

    assign two_mode = two_q;
    assign sel      = sel_q;

    AST_BAD_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && wdata[SEL_W-1:0] > SEL_LAST_LEGAL) |=> $stable(sel_q)); // R5
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q <= SEL_LAST_LEGAL); // R5
    AST_RSVD_BIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_we && bit_we && bit_idx > 3'(SEL_W-1) && bit_idx != 3'(CNT_BIT))
        |=> ($stable(sel_q) && $stable(two_q))); // R4

endmodule

// File: rtl/pgf_prescaler.sv
module pgf_prescaler
    import pgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             strobe
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    assign limit  = sel_to_limit(sel);
    assign strobe = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || strobe) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit); // R6
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !restart && limit != '0) |=> !strobe); // R6

endmodule

// File: rtl/pgf_sync.sv
module pgf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pgf_vote_fsm.sv
module pgf_vote_fsm
    import pgf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    input  logic strobe,
    input  logic two_mode,
    output logic level
);
    localparam int unsigned WAIT_W = $clog2(SYNC_STAGES + 1);
    localparam int unsigned VOTE_W = 2;

    flt_state_e         state_q, state_d;
    logic [VOTE_W-1:0]  vote_q, vote_d;
    logic [WAIT_W-1:0]  wait_q, wait_d;
    logic               lvl_q, lvl_d;
    logic [VOTE_W-1:0]  need;

    assign need = two_mode ? 2'd2 : 2'd3;

    // next state and next data
    always_comb begin
        state_d = state_q;
        vote_d  = vote_q;
        wait_d  = wait_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            FLT_INIT: begin
                if (wait_q == WAIT_W'(SYNC_STAGES)) begin
                    lvl_d   = sample;
                    state_d = FLT_STEADY;
                end else begin
                    wait_d = wait_q + 1'b1;
                end
            end
            FLT_STEADY: begin
                if (strobe && sample != lvl_q) begin
                    vote_d  = 2'd1;
                    state_d = FLT_PENDING;
                end
            end
            FLT_PENDING: begin
                if (strobe) begin
                    if (sample == lvl_q) begin
                        vote_d  = '0;
                        state_d = FLT_STEADY;
                    end else if (vote_q + 2'd1 >= need) begin
                        lvl_d   = sample;
                        vote_d  = '0;
                        state_d = FLT_STEADY;
                    end else begin
                        vote_d = vote_q + 2'd1;
                    end
                end
            end
            default: state_d = FLT_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_INIT;
        else        state_q <= state_d;
    end

    // data / output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vote_q <= '0;
            wait_q <= '0;
            lvl_q  <= 1'b0;
        end else begin
            vote_q <= vote_d;
            wait_q <= wait_d;
            lvl_q  <= lvl_d;
        end
    end

    assign level = lvl_q;

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FLT_INIT && !strobe) |=> $stable(lvl_q)); // R7
    AST_HOLD_ON_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FLT_INIT && strobe && sample == lvl_q) |=> $stable(lvl_q)); // R8
    AST_VOTE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vote_q <= 2'd2); // R7
    AST_INIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_INIT) |-> !lvl_q); // R10

endmodule

// File: rtl/pin_glitch_filter.sv
module pin_glitch_filter
    import pgf_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture_mode,
    input  logic       cfg_byte_we,
    input  logic [7:0] cfg_wdata,
    input  logic       cfg_bit_we,
    input  logic [2:0] cfg_bit_idx,
    input  logic       cfg_bit_val,
    output logic [7:0] cfg_rdata,
    input  logic       pin_raw,
    output logic       pin_out
);
    logic             two_mode;
    logic [SEL_W-1:0] sel;
    logic             sel_touch;
    logic             strobe;
    logic             pin_sync;
    logic             level;

    pgf_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (cfg_byte_we),
        .wdata     (cfg_wdata),
        .bit_we    (cfg_bit_we),
        .bit_idx   (cfg_bit_idx),
        .bit_val   (cfg_bit_val),
        .rdata     (cfg_rdata),
        .two_mode  (two_mode),
        .sel       (sel),
        .sel_touch (sel_touch)
    );

    pgf_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .restart (sel_touch),
        .strobe  (strobe)
    );

    pgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_raw),
        .q     (pin_sync)
    );

    pgf_vote_fsm #(.SYNC_STAGES(SYNC_STAGES)) u_vote (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample   (pin_sync),
        .strobe   (strobe),
        .two_mode (two_mode),
        .level    (level)
    );

    assign pin_out = capture_mode ? level : pin_raw;

endmodule

// File: tb/test_pin_glitch_filter.sv
`timescale 1ns/1ps
module test_pin_glitch_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       capture_mode = 1'b1;
    logic       cfg_byte_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cfg_bit_we = 1'b0;
    logic [2:0] cfg_bit_idx = 3'd0;
    logic       cfg_bit_val = 1'b0;
    logic       pin_raw = 1'b1;
    logic [7:0] cfg_rdata;
    logic       pin_out;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pin_glitch_filter i_pin_glitch_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_mode (capture_mode),
        .cfg_byte_we  (cfg_byte_we),
        .cfg_wdata    (cfg_wdata),
        .cfg_bit_we   (cfg_bit_we),
        .cfg_bit_idx  (cfg_bit_idx),
        .cfg_bit_val  (cfg_bit_val),
        .cfg_rdata    (cfg_rdata),
        .pin_raw      (pin_raw),
        .pin_out      (pin_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wr_byte(input logic [7:0] d, output int e0);
        @(negedge clk);
        cfg_byte_we = 1'b1;
        cfg_wdata   = d;
        @(negedge clk);
        cfg_byte_we = 1'b0;
        e0 = cyc;
    endtask

    task automatic wr_bit(input logic [2:0] idx, input logic v);
        @(negedge clk);
        cfg_bit_we  = 1'b1;
        cfg_bit_idx = idx;
        cfg_bit_val = v;
        @(negedge clk);
        cfg_bit_we  = 1'b0;
    endtask

    function automatic int ratio_of(input int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 16;
            4: return 32;
            default: return 64;
        endcase
    endfunction

    // write wval (restarts prescaler at e0), move pin to lvl at once, expect flip edge
    task automatic edge_test(input logic [7:0] wval, input int r, input int need,
                             input logic lvl, input string tag);
        int e0, s1, f;
        wr_byte(wval, e0);
        pin_raw = lvl;
        s1 = e0 + r * ((3 + r - 1) / r);
        f  = s1 + (need - 1) * r;
        while (cyc < f - 1) @(negedge clk);
        chk({tag, " before flip"}, int'(pin_out), int'(!lvl));
        @(negedge clk);
        chk({tag, " at flip"}, int'(pin_out), int'(lvl));
        repeat (4) @(negedge clk);
    endtask

    // pulse covering exactly need-1 samples must be rejected
    task automatic glitch_test(input int code, input int two);
        int e0, r, need, len;
        bit moved;
        r     = ratio_of(code);
        need  = two ? 2 : 3;
        len   = (need - 1) * r;
        moved = 1'b0;
        wr_byte({1'b0, 1'(two), 3'b000, 3'(code)}, e0);
        pin_raw = 1'b1;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (pin_out !== 1'b0) moved = 1'b1;
        end
        pin_raw = 1'b0;
        for (int k = 0; k < need * r + 6; k++) begin
            @(negedge clk);
            if (pin_out !== 1'b0) moved = 1'b1;
        end
        chk($sformatf("R8 glitch code %0d two %0d", code, two), int'(moved), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int e0;
        // R10 / R1: reset with pin held high
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset readback", int'(cfg_rdata), 8'h00);
        @(negedge clk);
        @(negedge clk);
        chk("R10 output low through edge 2", int'(pin_out), 0);
        @(negedge clk);
        chk("R10 output loads pin at edge 3", int'(pin_out), 1);
        pin_raw = 1'b0;
        repeat (10) @(negedge clk);
        chk("R7 settle low", int'(pin_out), 0);

        // R9: bypass
        capture_mode = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            pin_raw = k[0] ^ k[2];
            #1;
            chk("R9 bypass follows raw", int'(pin_out), int'(pin_raw));
        end
        pin_raw = 1'b0;
        repeat (10) @(negedge clk);
        capture_mode = 1'b1;
        chk("R9 filtered after bypass", int'(pin_out), 0);

        // register access
        wr_byte(8'h43, e0);
        chk("R3 byte write readback", int'(cfg_rdata), 8'h43);
        wr_byte(8'hFF, e0);
        chk("R2 R5 reserved and bad code", int'(cfg_rdata), 8'h43);
        wr_byte(8'hB9, e0);
        chk("R2 reserved bits drop", int'(cfg_rdata), 8'h01);
        wr_bit(3'd6, 1'b1);
        chk("R4 bit write count bit", int'(cfg_rdata), 8'h41);
        wr_bit(3'd7, 1'b1);
        chk("R4 reserved bit 7 write", int'(cfg_rdata), 8'h41);
        wr_bit(3'd3, 1'b1);
        chk("R4 reserved bit 3 write", int'(cfg_rdata), 8'h41);
        wr_bit(3'd1, 1'b1);
        chk("R4 bit write code bit 1", int'(cfg_rdata), 8'h43);
        wr_bit(3'd2, 1'b1);
        chk("R5 bit write to code 7 held", int'(cfg_rdata), 8'h43);
        wr_bit(3'd0, 1'b0);
        chk("R4 bit write code bit 0", int'(cfg_rdata), 8'h42);
        repeat (10) @(negedge clk);

        // R6 / R7 sweep over every code and both sample counts
        for (int code = 0; code < 6; code++) begin
            for (int two = 0; two < 2; two++) begin
                edge_test({1'b0, 1'(two), 3'b000, 3'(code)}, ratio_of(code), two ? 2 : 3,
                          1'b1, $sformatf("R6 R7 rise code %0d two %0d", code, two));
                edge_test({1'b0, 1'(two), 3'b000, 3'(code)}, ratio_of(code), two ? 2 : 3,
                          1'b0, $sformatf("R6 R7 fall code %0d two %0d", code, two));
            end
        end

        // R8 glitch rejection sweep
        for (int code = 0; code < 6; code++) begin
            for (int two = 0; two < 2; two++) begin
                glitch_test(code, two);
            end
        end

        // R5: bad code keeps the /16 rate (write still restarts the count)
        wr_byte(8'h03, e0);
        repeat (4) @(negedge clk);
        edge_test(8'h06, 16, 3, 1'b1, "R5 held divider rise");
        chk("R5 readback after bad code", int'(cfg_rdata), 8'h03);
        edge_test(8'h07, 16, 3, 1'b0, "R5 held divider fall");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule